// File: doc/BRIEF.md
# Eight-Bit Bidirectional Port Controller

This block controls a byte-wide general-purpose I/O port. Four byte registers sit behind a simple synchronous register bus: a latched output value, a pull-up request mask, a slew-limit request mask and a direction mask. The bus has an address, a write strobe, write data and registered read data. On the pad side the block drives a per-bit output value and output enable, plus per-bit pull-up and slew-control enables. It also takes a pin input byte that has already been synchronized.

Direction sets the behaviour of each bit. An output bit drives its latched value and may use slew limiting. An input bit shows its pin level when the value register is read, and may use a pull-up. The pull-up and slew controls sent to the pads are qualified by direction. Software still reads back the raw mask values it wrote.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, all four registers read 0x00. The pad outputs oe, pu_en and slew_en are all zero.
- R2: The register offsets are: 0 = output value, 1 = pull-up mask, 2 = slew mask, 3 = direction. A write with wr_en=1 updates the addressed register at the next clock edge.
- R3: Read data is registered. rd_data in the cycle after address A is presented shows the contents of A as they were in that earlier cycle.
- R4: Reading offset 0 returns, bit by bit, the pin input level where direction=0 and the latched value where direction=1.
- R5: A write to offset 0 latches all eight bits, including input bits. If an input bit is later turned into an output, it drives the latched value.
- R6: oe equals the direction register (1 = output), and pad_out equals the latched value register.
- R7: pu_en[i] = pull-up mask[i] AND NOT direction[i].
- R8: slew_en[i] = slew mask[i] AND direction[i].
- R9: The pull-up and slew masks read back their stored values whatever the direction register holds.
- R10: Reads of offsets 4 to 7 return 0x00, and writes to them change no register and no pad output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| pin_in | input | 8 | Synchronized pin levels |
| pad_out | output | 8 | Output value per bit |
| oe | output | 8 | Output enable per bit |
| pu_en | output | 8 | Pull-up enable per bit |
| slew_en | output | 8 | Slew-rate control enable per bit |

## Verification
A corrupted direction bit shows at once on oe and flips the gating of pu_en and slew_en on the same bit in the same cycle. It also changes which source that bit's value read selects, one cycle later. A wrong latched value shows on pad_out the cycle after the write. For an input bit, the fault stays hidden until the bit becomes an output or pad_out is compared. A decode fault in the read mux or at unmapped offsets shows on rd_data one cycle after the address.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    localparam int WIDTH  = 8;
    localparam int AW     = 3;

    typedef enum logic [AW-1:0] {
        OFS_VAL  = 3'd0,
        OFS_PULL = 3'd1,
        OFS_SLEW = 3'd2,
        OFS_DIR  = 3'd3
    } reg_ofs_e;

    typedef struct packed {
        logic [WIDTH-1:0] val;
        logic [WIDTH-1:0] pull;
        logic [WIDTH-1:0] slew;
        logic [WIDTH-1:0] dir;
    } port_regs_t;
endpackage

// File: rtl/gpio_reg_file.sv
module gpio_reg_file
    import gpio_port_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output port_regs_t       regs
);
    port_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            case (addr)
                OFS_VAL:  regs_d.val  = wr_data;
                OFS_PULL: regs_d.pull = wr_data;
                OFS_SLEW: regs_d.slew = wr_data;
                OFS_DIR:  regs_d.dir  = wr_data;
                default:  regs_d = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign regs = regs_q;
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
    import gpio_port_pkg::*;
(
    input  port_regs_t       regs,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] oe,
    output logic [WIDTH-1:0] pu_en,
    output logic [WIDTH-1:0] slew_en
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_comb begin
            pad_out[i] = regs.val[i];
            oe[i]      = regs.dir[i];
            pu_en[i]   = regs.pull[i] & ~regs.dir[i];
            slew_en[i] = regs.slew[i] &  regs.dir[i];
        end
    end
endmodule

// File: rtl/gpio_read_path.sv
module gpio_read_path
    import gpio_port_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr,
    input  port_regs_t       regs,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] rd_data
);
    logic [WIDTH-1:0] mixed;
    logic [WIDTH-1:0] rd_d, rd_q;

    for (genvar i = 0; i < WIDTH; i++) begin : g_mix
        assign mixed[i] = regs.dir[i] ? regs.val[i] : pin_in[i];
    end

    always_comb begin
        case (addr)
            OFS_VAL:  rd_d = mixed;
            OFS_PULL: rd_d = regs.pull;
            OFS_SLEW: rd_d = regs.slew;
            OFS_DIR:  rd_d = regs.dir;
            default:  rd_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_port_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       addr,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    output logic [7:0]       rd_data,
    input  logic [7:0]       pin_in,
    output logic [7:0]       pad_out,
    output logic [7:0]       oe,
    output logic [7:0]       pu_en,
    output logic [7:0]       slew_en
);
    port_regs_t regs;

    gpio_reg_file u_regs (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .wr_en(wr_en), .wr_data(wr_data), .regs(regs)
    );

    gpio_pad_ctrl u_pads (
        .regs(regs), .pad_out(pad_out), .oe(oe),
        .pu_en(pu_en), .slew_en(slew_en)
    );

    gpio_read_path u_rd (
        .clk(clk), .rst_n(rst_n), .addr(addr), .regs(regs),
        .pin_in(pin_in), .rd_data(rd_data)
    );
endmodule

// File: rtl/gpio_port_checker.sv
module gpio_port_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] addr,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic [7:0] pin_in,
    input logic [7:0] pad_out,
    input logic [7:0] oe,
    input logic [7:0] pu_en,
    input logic [7:0] slew_en
);
    // R7
    a_r7_pull_off_on_output: assert property (@(posedge clk) disable iff (!rst_n)
        (pu_en & oe) == 8'h00);
    // R8
    a_r8_slew_only_output: assert property (@(posedge clk) disable iff (!rst_n)
        (slew_en & ~oe) == 8'h00);
    // R2 / R6
    a_r6_dir_write_to_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd3) |=> (oe == $past(wr_data)));
    a_r6_val_write_to_pad: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd0) |=> (pad_out == $past(wr_data)));
    // R10
    a_r10_unmapped_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[2]) |=> (rd_data == 8'h00));
    a_r10_unmapped_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr[2]) |=> ($stable(oe) && $stable(pad_out)));
    // R3 / R4: registered read of direction offset
    a_r3_dir_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 3'd3) |=> (rd_data == $past(oe)));
endmodule

bind gpio_port_ctrl gpio_port_checker u_chk (.*);

// File: tb/tb_gpio_port_ctrl.sv
module tb_gpio_port_ctrl;
    logic       clk = 0;
    logic       rst_n = 0;
    logic [2:0] addr = 0;
    logic       wr_en = 0;
    logic [7:0] wr_data = 0;
    logic [7:0] rd_data;
    logic [7:0] pin_in = 0;
    logic [7:0] pad_out, oe, pu_en, slew_en;

    int total = 0;
    int bad = 0;

    // model
    logic [7:0] m_val = 0, m_pull = 0, m_slew = 0, m_dir = 0;

    gpio_port_ctrl dut (.*);

    always #4 clk = ~clk;

    initial begin
        #1600000;
        bad++; total++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    function automatic logic [7:0] exp_read(input logic [2:0] a, input logic [7:0] pins);
        case (a)
            3'd0: return (m_dir & m_val) | (~m_dir & pins);
            3'd1: return m_pull;
            3'd2: return m_slew;
            3'd3: return m_dir;
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic check_pads(input string req);
        check({req, " pad_out"}, pad_out, m_val);
        check({req, " oe"}, oe, m_dir);
        check({req, " pu_en"}, pu_en, m_pull & ~m_dir);
        check({req, " slew_en"}, slew_en, m_slew & m_dir);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_en = 1; wr_data = d;
        @(negedge clk);
        wr_en = 0;
        case (a)
            3'd0: m_val = d;
            3'd1: m_pull = d;
            3'd2: m_slew = d;
            3'd3: m_dir = d;
            default: ;
        endcase
    endtask

    task automatic rd(input string req, input logic [2:0] a);
        logic [7:0] e;
        @(negedge clk);
        addr = a; wr_en = 0;
        e = exp_read(a, pin_in);
        @(negedge clk);
        check(req, rd_data, e);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1
        check_pads("R1");
        for (int a = 0; a < 4; a++) rd("R1 reset read", 3'(a));
        rst_n = 1;
        @(negedge clk);
        for (int a = 0; a < 4; a++) rd("R1 reset read", 3'(a));
        check_pads("R1");

        // R5: latch into input bits, then flip to output
        pin_in = 8'h3C;
        wr(3'd0, 8'hA5);
        rd("R4 all inputs read pins", 3'd0);
        check("R5 pad_out latched while input", pad_out, 8'hA5);
        wr(3'd3, 8'h0F);
        check_pads("R5/R6");
        rd("R4 mixed read", 3'd0);
        wr(3'd3, 8'hFF);
        rd("R5 latched value after dir flip", 3'd0);

        // R7/R8/R9
        wr(3'd1, 8'hFF);
        wr(3'd2, 8'hFF);
        wr(3'd3, 8'hF0);
        check_pads("R7/R8");
        rd("R9 pull readback", 3'd1);
        rd("R9 slew readback", 3'd2);
        wr(3'd3, 8'h0F);
        check_pads("R7/R8 after dir change");
        rd("R9 pull readback", 3'd1);
        rd("R9 slew readback", 3'd2);

        // R10
        for (int a = 4; a < 8; a++) begin
            wr(3'(a), 8'h5A);
            check_pads("R10 write ignored");
            rd("R10 unmapped read", 3'(a));
        end
        for (int a = 0; a < 4; a++) rd("R10 regs unchanged", 3'(a));

        // R3: read latency - value changes on pin after sample are not seen
        @(negedge clk);
        addr = 3'd0; pin_in = 8'h00; wr_en = 0;
        @(posedge clk);
        #1 pin_in = 8'hFF;
        @(negedge clk);
        check("R3 registered read", rd_data, (m_dir & m_val));

        // random
        for (int i = 0; i < 400; i++) begin
            logic [2:0] a;
            logic [7:0] d;
            a = 3'($urandom_range(0, 7));
            d = 8'($urandom);
            pin_in = 8'($urandom);
            if ($urandom_range(0, 1) == 1) wr(a, d);
            else rd("R2/R4 random read", a);
            check_pads("R6/R7/R8 random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule